// File: doc/BRIEF.md
# Buffered Dual-Edge Input Capture Unit

This block timestamps external events. It has two capture channels, A and B. Each channel watches an asynchronous input pin. When the selected edge arrives on that pin, the channel stores the current value of a free-running counter that is supplied from outside. There are four 16-bit capture registers. Registers 0 and 1 are the main registers of channels A and B. Registers 2 and 3 can either capture on their own pins or serve as history buffers: register 2 for register 0, and register 3 for register 1.

Each channel has a buffer-enable bit. When that bit is set, each capture shifts the previous main value into the partner register. The edge-select bits of the main and partner registers then act together: they choose falling-only, rising-only or both-edge capture on the main pin.

Software reads the registers over an 8-bit port. Reading the high byte copies the low byte into a temporary latch, so the two bytes of a 16-bit read always belong to the same sample. Each load sets a sticky flag and drives a one-cycle pulse. A standby input clears all capture registers.

Top module: `cap_pair_unit`

## Requirements
- R1: An input change is synchronized through two flops and then compared with its value one clock earlier. The load happens on the third rising clock edge after the pin changes and stores `cnt_i` as sampled on that edge. For a pin changed just after a clock edge, that is the counter value presented two cycles after the change.
- R2: With a pair's buffer bit `buf_en_i[p]` clear, each register r captures on its own pin `cap_i[r]`. The edge is chosen by `edge_sel_i[r]`: 0 selects the falling edge, 1 the rising edge. The other edge has no effect.
- R3: With `buf_en_i[p]` set, every capture on main register p moves the old value of register p into register p+2 and loads `cnt_i` into register p, both in the same clock.
- R4: With `buf_en_i[p]` set, the edge on `cap_i[p]` is chosen as follows: unequal `edge_sel_i[p]` and `edge_sel_i[p+2]` give both edges, both 0 gives falling only, and both 1 gives rising only. In this mode, transitions on `cap_i[p+2]` change nothing.
- R5: While `standby_i` is high, all four capture registers read 0x0000. No load happens and no pulse is produced.
- R6: After reset, all capture registers read 0x0000, all flags are 0 and no capture pulse is active.
- R7: `flag_o[r]` is set by each load of register r and stays set until a 1 is written on `flag_clr_i[r]`. If a set and a clear arrive in the same cycle, the set wins.
- R8: `cap_pulse_o[r]` is high for exactly one cycle for each load of register r, and never otherwise.
- R9: When `rd_en_i` is high, `rd_addr_i[2:1]` selects a register and `rd_addr_i[0]` selects the byte. Byte 0 is the high byte, read directly, and reading it latches the low byte. Byte 1 returns that latched byte, even if the register has been loaded again since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Clears capture registers and blocks loads |
| cnt_i | input | CW | Free-running counter value |
| cap_i | input | 4 | Asynchronous capture pins, index = register |
| buf_en_i | input | 2 | Buffer enable per pair (bit 0 = A/2, bit 1 = B/3) |
| edge_sel_i | input | 4 | Edge select per register, 1 = rising |
| flag_clr_i | input | 4 | Write-one-to-clear strobes for the flags |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 3 | {register index, byte select} |
| rd_data_o | output | CW/2 | Read data byte, 0 when not reading |
| flag_o | output | 4 | Sticky capture flags |
| cap_pulse_o | output | 4 | One-cycle load strobes |

## Verification
The bound checker examines every cycle. It checks that a main load stores the previous cycle's counter value, that a buffered load moves the old main value into the partner register, and that registers hold still when no load is signalled. It also checks that standby zeroes the registers, that flags follow loads and clears, and that the temporary latch takes the low byte on every high-byte read. Only the bench scenarios can show that the edge choice is correct for every combination of buffer bit and edge-select pair, that toggling a partner pin in buffered mode does nothing, and that a split read returns the older low byte after a later capture.

// File: rtl/capu_pkg.sv
package capu_pkg;

  localparam int unsigned NREG  = 4;
  localparam int unsigned NPAIR = NREG / 2;

  // single-edge choice: 1 selects rising, 0 selects falling
  function automatic logic pick_edge(input logic want_rise, input logic rise, input logic fall);
    return want_rise ? rise : fall;
  endfunction

  // buffered choice from the pair's two select bits
  function automatic logic pair_edge(input logic sel_m, input logic sel_x,
                                     input logic rise, input logic fall);
    return (sel_m ^ sel_x) ? (rise | fall) : pick_edge(sel_m, rise, fall);
  endfunction

endpackage

// File: rtl/capu_sync_edge.sv
module capu_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/capu_pair.sv
module capu_pair
  import capu_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          buf_en,
  input  logic          sel_m,
  input  logic          sel_x,
  input  logic          rise_m,
  input  logic          fall_m,
  input  logic          rise_x,
  input  logic          fall_x,
  input  logic [CW-1:0] cnt,
  output logic          ld_m,
  output logic          ld_x,
  output logic [CW-1:0] q_m,
  output logic [CW-1:0] q_x
);
  logic hit_m, hit_x;

  always_comb begin
    if (buf_en) begin
      hit_m = pair_edge(sel_m, sel_x, rise_m, fall_m);
      hit_x = hit_m;
    end else begin
      hit_m = pick_edge(sel_m, rise_m, fall_m);
      hit_x = pick_edge(sel_x, rise_x, fall_x);
    end
    ld_m = hit_m & ~standby;
    ld_x = hit_x & ~standby;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_m <= '0;
      q_x <= '0;
    end else if (standby) begin
      q_m <= '0;
      q_x <= '0;
    end else begin
      if (ld_m) q_m <= cnt;
      if (ld_x) q_x <= buf_en ? q_m : cnt;
    end
  end
endmodule

// File: rtl/capu_flags.sv
module capu_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= (flag_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/capu_rdport.sv
module capu_rdport #(
  parameter int unsigned CW   = 16,
  parameter int unsigned NREG = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [2:0]                rd_addr,
  input  logic [NREG-1:0][CW-1:0]   regs,
  output logic [CW/2-1:0]           rd_data,
  output logic [CW/2-1:0]           tmp_o
);
  localparam int unsigned HW = CW / 2;

  logic [CW-1:0] sel_w;
  assign sel_w = regs[rd_addr[2:1]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tmp_o <= '0;
    else if (rd_en && !rd_addr[0]) tmp_o <= sel_w[HW-1:0];
  end

  always_comb begin
    if (!rd_en)          rd_data = '0;
    else if (rd_addr[0]) rd_data = tmp_o;
    else                 rd_data = sel_w[CW-1:HW];
  end
endmodule

// File: rtl/cap_pair_unit.sv
module cap_pair_unit
  import capu_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [3:0]        cap_i,
  input  logic [1:0]        buf_en_i,
  input  logic [3:0]        edge_sel_i,
  input  logic [3:0]        flag_clr_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_addr_i,
  output logic [CW/2-1:0]   rd_data_o,
  output logic [3:0]        flag_o,
  output logic [3:0]        cap_pulse_o
);
  // named internal events, observed by the bound checker
  logic [NREG-1:0]          rise_w;
  logic [NREG-1:0]          fall_w;
  logic [NREG-1:0]          ld_w;
  logic [NREG-1:0][CW-1:0]  cap_q;
  logic [CW/2-1:0]          tmp_q;

  for (genvar g = 0; g < NREG; g++) begin : g_sync
    capu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (cap_i[g]),
      .rise_o (rise_w[g]),
      .fall_o (fall_w[g])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    capu_pair #(.CW(CW)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .standby (standby_i),
      .buf_en  (buf_en_i[p]),
      .sel_m   (edge_sel_i[p]),
      .sel_x   (edge_sel_i[p+NPAIR]),
      .rise_m  (rise_w[p]),
      .fall_m  (fall_w[p]),
      .rise_x  (rise_w[p+NPAIR]),
      .fall_x  (fall_w[p+NPAIR]),
      .cnt     (cnt_i),
      .ld_m    (ld_w[p]),
      .ld_x    (ld_w[p+NPAIR]),
      .q_m     (cap_q[p]),
      .q_x     (cap_q[p+NPAIR])
    );
  end

  capu_flags #(.N(NREG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ld_w),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  capu_rdport #(.CW(CW), .NREG(NREG)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en_i),
    .rd_addr (rd_addr_i),
    .regs    (cap_q),
    .rd_data (rd_data_o),
    .tmp_o   (tmp_q)
  );

  assign cap_pulse_o = ld_w;
endmodule

// File: rtl/capu_chk.sv
module capu_chk #(
  parameter int unsigned CW = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                standby_i,
  input logic [CW-1:0]       cnt_i,
  input logic [1:0]          buf_en_i,
  input logic [3:0]          flag_clr_i,
  input logic                rd_en_i,
  input logic [2:0]          rd_addr_i,
  input logic [3:0]          flag_o,
  input logic [3:0]          rise_w,
  input logic [3:0]          fall_w,
  input logic [3:0]          ld_w,
  input logic [3:0][CW-1:0]  cap_q,
  input logic [CW/2-1:0]     tmp_q
);
  localparam int unsigned HW = CW / 2;

  logic [HW-1:0] low_sel;
  assign low_sel = cap_q[rd_addr_i[2:1]][HW-1:0];

  for (genvar p = 0; p < 2; p++) begin : g_p
    // R1
    main_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_w[p] |=> cap_q[p] == $past(cnt_i));
    // R3
    buf_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_w[p] && buf_en_i[p] |=> cap_q[p+2] == $past(cap_q[p]));
    // R2
    aux_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_w[p+2] && !buf_en_i[p] |=> cap_q[p+2] == $past(cnt_i));
    // R4
    main_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_w[p] |-> (rise_w[p] || fall_w[p]));
  end

  for (genvar i = 0; i < 4; i++) begin : g_r
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_w[i] && !standby_i |=> $stable(cap_q[i]));
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_w[i] |=> flag_o[i]);
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr_i[i] && !ld_w[i] |=> !flag_o[i]);
  end

  // R5
  standby_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (cap_q == '0));

  // R5
  standby_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |-> (ld_w == 4'b0000));

  // R9
  tmp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && !rd_addr_i[0] |=> tmp_q == $past(low_sel));
endmodule

bind cap_pair_unit capu_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .standby_i  (standby_i),
  .cnt_i      (cnt_i),
  .buf_en_i   (buf_en_i),
  .flag_clr_i (flag_clr_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .flag_o     (flag_o),
  .rise_w     (rise_w),
  .fall_w     (fall_w),
  .ld_w       (ld_w),
  .cap_q      (cap_q),
  .tmp_q      (tmp_q)
);

// File: tb/cap_pair_unit_tb.sv
`timescale 1ns/1ps
module cap_pair_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby_i = 1'b0;
  logic [15:0] cnt_i = '0;
  logic [3:0]  cap_i = '0;
  logic [1:0]  buf_en_i = '0;
  logic [3:0]  edge_sel_i = '0;
  logic [3:0]  flag_clr_i = '0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic [3:0]  flag_o;
  logic [3:0]  cap_pulse_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_q [4];
  logic [3:0]  m_flag;
  logic [15:0] base;

  always #2.5 clk = ~clk;

  cap_pair_unit u_dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .cnt_i(cnt_i),
    .cap_i(cap_i), .buf_en_i(buf_en_i), .edge_sel_i(edge_sel_i),
    .flag_clr_i(flag_clr_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .flag_o(flag_o), .cap_pulse_o(cap_pulse_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd16(input int idx, output logic [15:0] v);
    rd_en_i = 1'b1;
    rd_addr_i = {idx[1:0], 1'b0};
    #1 v[15:8] = rd_data_o;
    @(negedge clk);
    rd_addr_i = {idx[1:0], 1'b1};
    #1 v[7:0] = rd_data_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  // expected loads from the requirements (R2, R4)
  function automatic logic [3:0] model_ld(input int r, input logic lvl);
    logic [3:0] ld = '0;
    int p = r % 2;
    if (buf_en_i[p]) begin
      if (r < 2) begin
        if (edge_sel_i[p] != edge_sel_i[p+2]) ld[p] = 1'b1;
        else ld[p] = edge_sel_i[p] ? lvl : !lvl;
        ld[p+2] = ld[p];
      end
    end else begin
      ld[r] = edge_sel_i[r] ? lvl : !lvl;
    end
    return ld;
  endfunction

  task automatic do_edge(input int r, input logic lvl, input logic [15:0] b);
    logic [3:0] eld;
    int pc [4];
    logic [15:0] v;
    eld = standby_i ? 4'b0000 : model_ld(r, lvl);
    for (int i = 0; i < 4; i++) pc[i] = 0;
    cap_i[r] = lvl;
    cnt_i = b;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (cap_pulse_o[i]) pc[i]++;
      cnt_i = b + 16'(k);
    end
    v = b + 16'd2;
    if (standby_i) begin
      for (int i = 0; i < 4; i++) m_q[i] = '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (buf_en_i[p]) begin
          if (eld[p]) begin m_q[p+2] = m_q[p]; m_q[p] = v; end
        end else begin
          if (eld[p])   m_q[p]   = v;
          if (eld[p+2]) m_q[p+2] = v;
        end
      end
    end
    m_flag = m_flag | eld;
    for (int i = 0; i < 4; i++) check("R8 pulse count", pc[i], {31'b0, eld[i]});
  endtask

  task automatic verify(input string tag);
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      rd16(i, v);
      check(tag, v, m_q[i]);
    end
    check("R7 flags", flag_o, m_flag);
    flag_clr_i = 4'hF;
    @(negedge clk);
    flag_clr_i = 4'h0;
    #1 check("R7 w1c", flag_o, 4'h0);
    m_flag = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v1, v2, hv;
    string tg;
    for (int i = 0; i < 4; i++) m_q[i] = '0;
    m_flag = '0;
    base = 16'h1357;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6 pulse", cap_pulse_o, 4'h0);
    check("R6 flags", flag_o, 4'h0);
    verify("R6 reg");

    // R1 R2 R3 R4 sweep: both pairs, buffer on/off, all select pairs, both directions
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 2; b++) begin
        for (int es = 0; es < 4; es++) begin
          buf_en_i = '0;
          buf_en_i[p] = b[0];
          edge_sel_i = '0;
          edge_sel_i[p] = es[0];
          edge_sel_i[p+2] = es[1];
          tg = b[0] ? "R3 R4 buffered" : "R1 R2 unbuffered";
          for (int d = 0; d < 2; d++) begin
            do_edge(p, d == 0, base);
            base = base + 16'h0A3B;
            verify(tg);
            do_edge(p + 2, d == 0, base);
            base = base + 16'h0A3B;
            verify(tg);
          end
        end
      end
    end

    // R5 standby clears and blocks a capture
    buf_en_i = 2'b00;
    edge_sel_i = 4'hF;
    standby_i = 1'b1;
    do_edge(0, 1'b1, 16'hBEEF);
    verify("R5 standby");
    do_edge(0, 1'b0, 16'hBEEF);
    standby_i = 1'b0;
    @(negedge clk);
    verify("R5 after standby");

    // R9 split read across a new capture
    edge_sel_i = 4'b0001;
    do_edge(0, 1'b1, 16'h5AC3);
    v1 = m_q[0];
    rd_en_i = 1'b1;
    rd_addr_i = 3'b000;
    #1 hv[15:8] = rd_data_o;
    @(negedge clk);
    rd_en_i = 1'b0;
    check("R9 high byte", hv[15:8], v1[15:8]);
    edge_sel_i = 4'b0000;
    do_edge(0, 1'b0, 16'h9E21);
    v2 = m_q[0];
    rd_en_i = 1'b1;
    rd_addr_i = 3'b001;
    #1 check("R9 low byte from latch", rd_data_o, v1[7:0]);
    @(negedge clk);
    rd_en_i = 1'b0;
    #1 check("R9 idle data", rd_data_o, 8'h00);
    rd16(0, hv);
    check("R9 fresh read", hv, v2);
    verify("R9 final");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule